// File: doc/BRIEF.md
# Three-Phase 8-Bit Load/Store Processor Core

This block is a small 8-bit processor with four general registers and one memory port. Code and data share a 256-byte space. Every instruction takes exactly three clock cycles. The first cycle fetches the opcode byte into the instruction register. The second cycle fetches an immediate byte, but only for two-byte instructions. The third cycle executes the instruction.

The instruction set has sixteen opcodes:
- two-operand ALU operations, where the destination register is both an input and the result;
- loads and stores that take the address from a register or from the immediate byte;
- a register move, a load-immediate and a no-op;
- jumps to an absolute address held in the immediate byte. Conditional jumps test the destination register's value directly, because the core has no flag register.

The memory sits outside the core. It must return read data in the same cycle that the address is presented. It latches a write on the clock edge that ends a cycle in which the write enable is high.

Top module: `pcore_top`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the four registers and the phase counter. While reset is held, and in the first cycle after it, `mem_addr` is 0x00 and `mem_we` is low.
- R2: The phase order is fetch, immediate slot, execute, and then fetch again.
  - The program counter increments after every fetch.
  - In the immediate slot, the program counter increments and the immediate register loads only when opcode bit 7 is 1. When bit 7 is 0, the program counter holds.
- R3: The instruction byte holds the opcode in bits [7:4], the destination register index Rd in bits [3:2] and the source register index Rs in bits [1:0].
- R4: Opcodes 0000 AND, 0001 OR, 0010 ADD and 0011 SUB compute Rd = Rd op Rs. ADD and SUB wrap modulo 256.
- R5: The register-write opcodes are:
  - 0100 loads Rd from memory at address Rs.
  - 1100 loads Rd from memory at the immediate address.
  - 0110 copies Rs into Rd.
  - 1110 loads the immediate byte into Rd.
- R6: Opcode 0101 stores Rd at address Rs, and opcode 1101 stores Rd at the immediate address. `mem_we` is high only in the execute cycle of these two opcodes, and `mem_wdata` then carries Rd.
- R7: Opcodes 1000, 1001, 1010 and 1011 load the program counter from the immediate byte under these conditions, reading Rd as a two's-complement value:
  - 1000 when Rd is zero;
  - 1001 when Rd is nonzero;
  - 1010 when Rd is greater than zero;
  - 1011 when Rd is less than zero.
  When the condition is false, execution continues with the next instruction.
- R8: Opcode 1111 always loads the program counter from the immediate byte. Opcode 0111 changes no register and no memory.
- R9: `mem_addr` carries the program counter in the following cycles:
  - the fetch cycle;
  - the immediate-slot cycle;
  - the execute cycle of every opcode other than a load or a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Store data (destination register) |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_we | output | 1 | Write strobe |

## Verification
The bench targets the signed jump conditions at their edges:
- a value of zero must not satisfy the greater-than jump;
- a value with the MSB set must take the less-than jump and refuse the greater-than jump.

A core that tested only the MSB, or only the zero flag, would take a forbidden path and store a marker byte. The bench also checks these cases:
- In one-byte instructions, the program counter must hold in the immediate slot. A core that advanced it would skip bytes, and the per-cycle address comparison would diverge.
- Both store forms must take the correct address source.
- ADD and SUB must wrap around zero.
- The summing loop must end correctly on an empty list.

// File: rtl/pcore_pkg.sv
`timescale 1ns/1ps
package pcore_pkg;
  localparam int DW   = 8;
  localparam int NREG = 4;
  localparam int RIW  = $clog2(NREG);
  localparam int OPW  = 4;

  typedef logic [DW-1:0] word_t;

  typedef enum logic [1:0] {PH_FETCH = 2'd0, PH_IMM = 2'd1, PH_EXEC = 2'd2} phase_t;
  typedef enum logic [1:0] {AS_PC = 2'd0, AS_IMM = 2'd1, AS_SRC = 2'd2} asel_t;
  typedef enum logic [1:0] {WS_IMM = 2'd0, WS_SRC = 2'd1, WS_MEM = 2'd2, WS_ALU = 2'd3} wsel_t;

  localparam logic [OPW-1:0] OP_AND = 4'h0, OP_OR  = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3;
  localparam logic [OPW-1:0] OP_LDR = 4'h4, OP_STR = 4'h5, OP_MOV = 4'h6, OP_NOP = 4'h7;
  localparam logic [OPW-1:0] OP_JZ  = 4'h8, OP_JNZ = 4'h9, OP_JPOS = 4'hA, OP_JNEG = 4'hB;
  localparam logic [OPW-1:0] OP_LDA = 4'hC, OP_STA = 4'hD, OP_LDI = 4'hE, OP_JMP = 4'hF;

  function automatic word_t alu_f(input logic [1:0] sel, input word_t d, input word_t s);
    case (sel)
      2'd0:    return d & s;
      2'd1:    return d | s;
      2'd2:    return d + s;
      default: return d - s;
    endcase
  endfunction

  function automatic logic jump_ok(input logic [1:0] sel, input word_t v);
    logic is_zero, is_neg;
    is_zero = (v == '0);
    is_neg  = v[DW-1];
    case (sel)
      2'd0:    return is_zero;
      2'd1:    return !is_zero;
      2'd2:    return !is_zero && !is_neg;
      default: return is_neg;
    endcase
  endfunction
endpackage

// File: rtl/pcore_phase.sv
`timescale 1ns/1ps
module pcore_phase import pcore_pkg::*; (
  input  logic   clk,
  input  logic   rst,
  output phase_t ph
);
  always_ff @(posedge clk) begin
    if (rst) ph <= PH_FETCH;
    else begin
      case (ph)
        PH_FETCH: ph <= PH_IMM;
        PH_IMM:   ph <= PH_EXEC;
        default:  ph <= PH_FETCH;
      endcase
    end
  end

  assert_exec_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    ph == PH_EXEC |=> ph == PH_FETCH);
  assert_fetch_then_slot_R2: assert property (@(posedge clk) disable iff (rst)
    ph == PH_FETCH |=> ph == PH_IMM);
endmodule

// File: rtl/pcore_regfile.sv
`timescale 1ns/1ps
module pcore_regfile import pcore_pkg::*; #(
  parameter int NR = NREG,
  parameter int W  = DW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [$clog2(NR)-1:0] widx,
  input  logic [W-1:0]          wdata,
  input  logic [$clog2(NR)-1:0] dsel,
  input  logic [$clog2(NR)-1:0] ssel,
  output logic [W-1:0]          dval,
  output logic [W-1:0]          sval
);
  localparam int IW = $clog2(NR);

  logic [NR-1:0][W-1:0] bank;

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (we && widx == IW'(g)) q <= wdata;
    end
    assign bank[g] = q;
  end

  assign dval = bank[dsel];
  assign sval = bank[ssel];

  assert_bank_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bank));
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> bank[$past(widx)] == $past(wdata));
endmodule

// File: rtl/pcore_decode.sv
`timescale 1ns/1ps
module pcore_decode import pcore_pkg::*; (
  input  phase_t         ph,
  input  logic [OPW-1:0] op,
  input  word_t          dval,
  output logic           ir_ld,
  output logic           imm_ld,
  output logic           pc_inc,
  output logic           pc_jmp,
  output asel_t          asel,
  output logic           mem_we,
  output logic           rf_we,
  output wsel_t          wsel
);
  logic two_byte;
  logic cond_hit;

  assign two_byte = op[OPW-1];
  assign cond_hit = jump_ok(op[1:0], dval);

  always_comb begin
    ir_ld  = 1'b0;
    imm_ld = 1'b0;
    pc_inc = 1'b0;
    pc_jmp = 1'b0;
    asel   = AS_PC;
    mem_we = 1'b0;
    rf_we  = 1'b0;
    wsel   = WS_ALU;
    case (ph)
      PH_FETCH: begin
        ir_ld  = 1'b1;
        pc_inc = 1'b1;
      end
      PH_IMM: begin
        imm_ld = two_byte;
        pc_inc = two_byte;
      end
      PH_EXEC: begin
        case (op)
          OP_AND, OP_OR, OP_ADD, OP_SUB: begin
            rf_we = 1'b1;
            wsel  = WS_ALU;
          end
          OP_LDR: begin
            asel  = AS_SRC;
            rf_we = 1'b1;
            wsel  = WS_MEM;
          end
          OP_STR: begin
            asel   = AS_SRC;
            mem_we = 1'b1;
          end
          OP_MOV: begin
            rf_we = 1'b1;
            wsel  = WS_SRC;
          end
          OP_JZ, OP_JNZ, OP_JPOS, OP_JNEG: pc_jmp = cond_hit;
          OP_LDA: begin
            asel  = AS_IMM;
            rf_we = 1'b1;
            wsel  = WS_MEM;
          end
          OP_STA: begin
            asel   = AS_IMM;
            mem_we = 1'b1;
          end
          OP_LDI: begin
            rf_we = 1'b1;
            wsel  = WS_IMM;
          end
          OP_JMP: pc_jmp = 1'b1;
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcore_top.sv
`timescale 1ns/1ps
module pcore_top import pcore_pkg::*; (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we
);
  phase_t ph;
  word_t  pc, ir, imm;
  word_t  dval, sval, rf_wdata;
  logic   ir_ld, imm_ld, pc_inc, pc_jmp, rf_we;
  asel_t  asel;
  wsel_t  wsel;

  logic [OPW-1:0] op;
  logic [RIW-1:0] rd_idx, rs_idx;
  assign op     = ir[DW-1 -: OPW];
  assign rd_idx = ir[2*RIW-1 -: RIW];
  assign rs_idx = ir[RIW-1:0];

  pcore_phase u_phase (.clk(clk), .rst(rst), .ph(ph));

  pcore_decode u_dec (
    .ph(ph), .op(op), .dval(dval),
    .ir_ld(ir_ld), .imm_ld(imm_ld), .pc_inc(pc_inc), .pc_jmp(pc_jmp),
    .asel(asel), .mem_we(mem_we), .rf_we(rf_we), .wsel(wsel)
  );

  pcore_regfile #(.NR(NREG), .W(DW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .widx(rd_idx), .wdata(rf_wdata),
    .dsel(rd_idx), .ssel(rs_idx), .dval(dval), .sval(sval)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      imm <= '0;
    end else begin
      if (ir_ld)  ir  <= mem_rdata;
      if (imm_ld) imm <= mem_rdata;
      if (pc_jmp)      pc <= imm;
      else if (pc_inc) pc <= pc + 1'b1;
    end
  end

  always_comb begin
    case (asel)
      AS_IMM:  mem_addr = imm;
      AS_SRC:  mem_addr = sval;
      default: mem_addr = pc;
    endcase
  end

  always_comb begin
    case (wsel)
      WS_IMM:  rf_wdata = imm;
      WS_SRC:  rf_wdata = sval;
      WS_MEM:  rf_wdata = mem_rdata;
      default: rf_wdata = alu_f(op[1:0], dval, sval);
    endcase
  end

  assign mem_wdata = dval;

  assert_slot_addr_is_pc_R9: assert property (@(posedge clk) disable iff (rst)
    ph != PH_EXEC |-> mem_addr == pc);
  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    ph == PH_FETCH |=> pc == DW'($past(pc) + 1'b1));
  assert_short_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IMM && !ir[DW-1]) |=> pc == $past(pc));
  assert_jmp_target_R8: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_EXEC && op == OP_JMP) |=> pc == $past(imm));
  assert_we_exec_only_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ph == PH_EXEC);
  assert_short_exec_keeps_pc_R7: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_EXEC && !ir[DW-1]) |=> $stable(pc));
endmodule

// File: tb/pcore_top_tb.sv
`timescale 1ns/1ps
module pcore_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we;

  always #2 clk = ~clk;

  logic [7:0] dmem [256];
  logic [7:0] rmem [256];
  assign mem_rdata = dmem[mem_addr];

  pcore_top dut_i (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                   .mem_rdata(mem_rdata), .mem_we(mem_we));

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 1'b0;
  int lp = 0;

  logic [1:0] m_ph;
  logic [7:0] m_pc, m_ir, m_imm;
  logic [7:0] m_r [4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_addr();
    logic [3:0] o;
    o = m_ir[7:4];
    if (m_ph != 2'd2) return m_pc;
    if (o == 4'h4 || o == 4'h5) return m_r[m_ir[1:0]];
    if (o == 4'hC || o == 4'hD) return m_imm;
    return m_pc;
  endfunction

  function automatic bit m_we();
    return m_ph == 2'd2 && (m_ir[7:4] == 4'h5 || m_ir[7:4] == 4'hD);
  endfunction

  task automatic model_step();
    logic [7:0] din;
    logic [1:0] d, s;
    din = rmem[m_addr()];
    d = m_ir[3:2];
    s = m_ir[1:0];
    if (m_ph == 2'd0) begin
      m_ir = din; m_pc = m_pc + 8'd1; m_ph = 2'd1;
    end else if (m_ph == 2'd1) begin
      if (m_ir[7]) begin m_imm = din; m_pc = m_pc + 8'd1; end
      m_ph = 2'd2;
    end else begin
      case (m_ir[7:4])
        4'h0: m_r[d] = m_r[d] & m_r[s];
        4'h1: m_r[d] = m_r[d] | m_r[s];
        4'h2: m_r[d] = m_r[d] + m_r[s];
        4'h3: m_r[d] = m_r[d] - m_r[s];
        4'h4: m_r[d] = din;
        4'h5: rmem[m_r[s]] = m_r[d];
        4'h6: m_r[d] = m_r[s];
        4'h8: if (m_r[d] == 8'd0) m_pc = m_imm;
        4'h9: if (m_r[d] != 8'd0) m_pc = m_imm;
        4'hA: if ($signed(m_r[d]) > 0) m_pc = m_imm;
        4'hB: if ($signed(m_r[d]) < 0) m_pc = m_imm;
        4'hC: m_r[d] = din;
        4'hD: rmem[m_imm] = m_r[d];
        4'hE: m_r[d] = m_imm;
        4'hF: m_pc = m_imm;
        default: ;
      endcase
      m_ph = 2'd0;
    end
  endtask

  always @(posedge clk) begin
    if (mem_we) dmem[mem_addr] <= mem_wdata;
    if (rst) begin
      m_ph = 2'd0; m_pc = 8'd0; m_ir = 8'd0; m_imm = 8'd0;
      for (int i = 0; i < 4; i++) m_r[i] = 8'd0;
    end else model_step();
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      string tag;
      logic [3:0] o;
      o = m_ir[7:4];
      if (m_ph == 2'd0) tag = "R9";
      else if (m_ph == 2'd1) tag = "R2";
      else if (o == 4'h4 || o == 4'hC) tag = "R5";
      else if (o == 4'h5 || o == 4'hD) tag = "R6";
      else if (o[3:2] == 2'b10) tag = "R7";
      else if (o == 4'hF || o == 4'h7) tag = "R8";
      else tag = "R4";
      chk(mem_addr == m_addr(), {tag, " address"}, mem_addr, m_addr());
      chk(mem_we == m_we(), "R6 write strobe", mem_we, m_we());
      if (m_we()) chk(mem_wdata == m_r[m_ir[3:2]], "R6 store data", mem_wdata, m_r[m_ir[3:2]]);
    end
  end

  function automatic logic [7:0] ins(input int o, input int d, input int s);
    return {o[3:0], d[1:0], s[1:0]};
  endfunction

  task automatic put(input logic [7:0] b);
    dmem[lp] = b; rmem[lp] = b; lp++;
  endtask
  task automatic put2(input logic [7:0] b, input logic [7:0] im);
    put(b); put(im);
  endtask
  task automatic poke(input int a, input logic [7:0] b);
    dmem[a] = b; rmem[a] = b;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    cmp_en = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(mem_addr == 8'h00, "R1 reset address", mem_addr, 0);
    chk(mem_we == 1'b0, "R1 reset strobe", mem_we, 0);
  endtask

  task automatic leave_reset();
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    chk(mem_addr == 8'h00 && mem_we == 1'b0, "R1 first fetch", mem_addr, 0);
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sum_run(input logic [7:0] lst [$]);
    logic [7:0] total;
    enter_reset();
    for (int a = 0; a < 256; a++) poke(a, 8'h00);
    poke(8'h40, 8'hAA);
    lp = 0;
    put2(ins(14, 1, 0), 8'h00);
    put2(ins(14, 0, 0), 8'h80);
    put(ins(4, 2, 0));
    put2(ins(8, 2, 0), 8'h0D);
    put(ins(2, 1, 2));
    put2(ins(14, 3, 0), 8'h01);
    put(ins(2, 0, 3));
    put2(ins(15, 0, 0), 8'h04);
    put2(ins(13, 1, 0), 8'h40);
    put2(ins(15, 0, 0), 8'h0F);
    total = 8'h00;
    foreach (lst[i]) begin
      poke(8'h80 + i, lst[i]);
      total = total + lst[i];
    end
    leave_reset();
    run(400);
    @(negedge clk);
    chk(dmem[8'h40] == total, "R4 R5 R7 list sum", dmem[8'h40], total);
  endtask

  task automatic tour_run();
    enter_reset();
    for (int a = 0; a < 256; a++) poke(a, (a >= 8'hC0 && a < 8'hF0) ? 8'h00 : 8'h70);
    lp = 8'h00;
    put2(ins(14, 0, 0), 8'h3C); put2(ins(14, 1, 0), 8'h0F);
    put(ins(0, 0, 1));          put2(ins(13, 0, 0), 8'hC0);
    put2(ins(14, 2, 0), 8'hA0); put(ins(1, 2, 1));
    put2(ins(13, 2, 0), 8'hC1);
    put(ins(3, 1, 0));          put2(ins(13, 1, 0), 8'hC2);
    put(ins(6, 3, 2));          put(ins(7, 0, 0));
    put2(ins(13, 3, 0), 8'hC3);
    put2(ins(11, 3, 0), 8'h20); put2(ins(14, 0, 0), 8'hEE);
    lp = 8'h20;
    put2(ins(10, 3, 0), 8'hF0); put2(ins(8, 1, 0), 8'hF0);
    put2(ins(9, 1, 0), 8'h30);  put2(ins(14, 0, 0), 8'hEE);
    lp = 8'h30;
    put2(ins(14, 2, 0), 8'h55); put2(ins(14, 3, 0), 8'hD0);
    put(ins(5, 2, 3));
    put2(ins(12, 1, 0), 8'hD0); put2(ins(13, 1, 0), 8'hC4);
    put2(ins(14, 0, 0), 8'h00); put2(ins(10, 0, 0), 8'hF0);
    put2(ins(8, 0, 0), 8'h48);  put2(ins(14, 0, 0), 8'hEE);
    lp = 8'h48;
    put2(ins(13, 0, 0), 8'hC5); put2(ins(14, 1, 0), 8'h01);
    put2(ins(10, 1, 0), 8'h58); put2(ins(14, 0, 0), 8'hEE);
    lp = 8'h58;
    put2(ins(13, 0, 0), 8'hC6);
    put2(ins(14, 2, 0), 8'h05); put2(ins(14, 3, 0), 8'h07);
    put(ins(3, 2, 3));          put2(ins(13, 2, 0), 8'hC8);
    put2(ins(15, 0, 0), 8'h61);
    lp = 8'hF0;
    put2(ins(14, 0, 0), 8'hBB); put2(ins(13, 0, 0), 8'hC7);
    put2(ins(15, 0, 0), 8'hF4);
    leave_reset();
    run(300);
    @(negedge clk);
    chk(dmem[8'hC0] == 8'h0C, "R4 AND result",             dmem[8'hC0], 8'h0C);
    chk(dmem[8'hC1] == 8'hAF, "R4 OR result",              dmem[8'hC1], 8'hAF);
    chk(dmem[8'hC2] == 8'h03, "R4 SUB result",             dmem[8'hC2], 8'h03);
    chk(dmem[8'hC3] == 8'hAF, "R3 R5 R8 move across nop",  dmem[8'hC3], 8'hAF);
    chk(dmem[8'hD0] == 8'h55, "R6 register-address store", dmem[8'hD0], 8'h55);
    chk(dmem[8'hC4] == 8'h55, "R5 immediate-address load", dmem[8'hC4], 8'h55);
    chk(dmem[8'hC5] == 8'h00, "R7 zero jump skips",        dmem[8'hC5], 8'h00);
    chk(dmem[8'hC6] == 8'h00, "R7 positive jump skips",    dmem[8'hC6], 8'h00);
    chk(dmem[8'hC7] == 8'h00, "R7 no false jump taken",    dmem[8'hC7], 8'h00);
    chk(dmem[8'hC8] == 8'hFE, "R4 SUB wraps below zero",   dmem[8'hC8], 8'hFE);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    sum_run('{8'd3, 8'd5, 8'd7, 8'd10});
    sum_run('{8'hF0, 8'h20, 8'h01});
    sum_run('{});
    tour_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule